// File: doc/BRIEF.md
# Mode-Selectable Result Rounding Unit

This block turns an unrounded arithmetic result into a 40-bit register word. It accepts one of four kinds of source, chosen per transfer. The first is a single-precision float given as sign, biased exponent and a normalized extended mantissa. The second is a two's-complement fractional product in 1.63 form. The third is an integer product. The fourth is a 40-bit register being read as an operand. The 32-bit outcome always sits in bits 39:8 of the word, and bits 7:0 are cleared.

A single mode bit, `rnd_trunc`, picks the rounding rule. When it is 1, results round toward zero. When it is 0, results round to the nearest value, and an exact tie goes to the value with a zero LSB. The mode bit affects float and fractional results only. Integer results are always truncated, and operand extraction never rounds. One register stage holds the result. A transfer accepted with `valid_in` appears one clock later with `valid_out`.

Float mantissa layout: bit 47 is the hidden leading one. Bits 46:24 are the 23 fraction bits kept. Bit 23 is the guard bit. Bits 22:0 feed the sticky bit. An exponent of 0 means the result is flushed to zero. An exponent of 255 means the unrounded value is already beyond the finite range.

Top module: `rnd_unit`

## Requirements
- R1: The result word carries its 32-bit value in bits 39:8, and bits 7:0 of a valid result are always zero.
- R2: After reset, `valid_out` and `res_word` are zero. `valid_out` equals `valid_in` of the previous clock. A clock without `valid_in` leaves `res_word` unchanged.
- R3: Float (`fmt`=0) with `rnd_trunc`=1 keeps the 24-bit significand and drops the guard and sticky bits. This truncates the magnitude, whatever the sign. The output is packed as sign in bit 39, exponent in 38:31 and fraction in 30:8.
- R4: Float with `rnd_trunc`=0 rounds the magnitude up when the guard bit is set and either the sticky bit or the kept LSB is set. An exact tie therefore resolves to an even significand.
- R5: When rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent increases by one.
- R6: In nearest mode, a float whose rounded exponent reaches 255, including a tie just above the largest finite magnitude, gives infinity with the input's sign (exponent 255, fraction 0).
- R7: In toward-zero mode, a float whose exponent is 255 saturates to the largest finite magnitude (exponent 254, fraction all ones) with the input's sign. It never gives infinity.
- R8: A float with exponent 0 gives a zero of the input's sign, whatever the mantissa.
- R9: Fractional (`fmt`=1) with `rnd_trunc`=1 returns bits 63:32 of the product. One LSB is added when the product is negative and bits 31:0 are non-zero, so the magnitude moves toward zero.
- R10: Fractional with `rnd_trunc`=0 rounds bits 63:32 to nearest, with ties to even. If rounding up would overflow the most positive value, the result saturates to 0x7FFFFFFF.
- R11: Integer (`fmt`=2) returns bits 31:0 of the product unchanged, whatever `rnd_trunc` is.
- R12: Operand extraction (`fmt`=3) returns `reg_in[39:8]`. Bits 7:0 of `reg_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Inputs are valid this clock |
| fmt | input | 2 | Source kind: 0 float, 1 fractional, 2 integer, 3 operand |
| rnd_trunc | input | 1 | 1 = round toward zero, 0 = round to nearest even |
| f_sign | input | 1 | Float sign |
| f_exp | input | 8 | Float biased exponent |
| f_mant | input | 48 | Float extended mantissa, hidden one at bit 47 |
| fx_prod | input | 64 | Fractional 1.63 or integer product |
| reg_in | input | 40 | Register word for operand extraction |
| valid_out | output | 1 | Result word is valid |
| res_word | output | 40 | Rounded 40-bit result word |

## Verification
The assertions assume that a float with a non-zero exponent below 255 arrives with its hidden bit set. They also assume that the unrounded exponent never exceeds 255. Inside those bounds, the carry and saturation checks describe the real result. Every vector the stimulus applies has bit 47 of the mantissa set whenever the exponent is in the normal range. It reaches overflow only through exponent 255 or through a carry out of 254. The fractional vectors never present the single out-of-range product from minus one times minus one.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    FMT_FLT  = 2'd0,
    FMT_FRAC = 2'd1,
    FMT_INT  = 2'd2,
    FMT_OPND = 2'd3
  } rnd_fmt_e;
endpackage

// File: rtl/rnd_flt_core.sv
module rnd_flt_core #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MANT_W = 48
) (
  input  logic                    sign,
  input  logic [EXP_W-1:0]        exp_in,
  input  logic [MANT_W-1:0]       mant,
  input  logic                    trunc,
  output logic [EXP_W+FRAC_W:0]   word,
  output logic                    carry_ev
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = MANT_W - SIG_W;
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  // nearest-even decision: guard set, and either sticky or odd lsb
  function automatic logic nearest_up(input logic lsb, input logic g, input logic s);
    return g & (s | lsb);
  endfunction

  logic [SIG_W-1:0] sig;
  logic             guard, sticky, inc;
  logic [SIG_W:0]   sum;
  logic             cy;
  logic [SIG_W-1:0] sig_n;
  logic [EXP_W-1:0] exp_n;
  logic             is_zero, in_ovf, ovf;

  assign sig     = mant[MANT_W-1 -: SIG_W];
  assign guard   = mant[EXT_W-1];
  assign sticky  = |mant[EXT_W-2:0];
  assign inc     = !trunc && nearest_up(sig[0], guard, sticky);
  assign sum     = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
  assign cy      = sum[SIG_W];
  assign sig_n   = cy ? sum[SIG_W:1] : sum[SIG_W-1:0];
  assign exp_n   = exp_in + {{(EXP_W-1){1'b0}}, cy};
  assign is_zero = (exp_in == '0);
  assign in_ovf  = (exp_in == EXP_TOP);
  assign ovf     = in_ovf || (exp_n == EXP_TOP);
  assign carry_ev = cy && !is_zero && !in_ovf;

  always_comb begin
    if (is_zero)
      word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    else if (ovf && trunc)
      word = {sign, EXP_TOP - 1'b1, {FRAC_W{1'b1}}};
    else if (ovf)
      word = {sign, EXP_TOP, {FRAC_W{1'b0}}};
    else
      word = {sign, exp_n, sig_n[FRAC_W-1:0]};
  end
endmodule

// File: rtl/rnd_frac_core.sv
module rnd_frac_core #(
  parameter int PROD_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [PROD_W-1:0] prod,
  input  logic              trunc,
  output logic [WORD_W-1:0] word,
  output logic              sat_ev
);
  localparam int LO_W = PROD_W - WORD_W;
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};

  function automatic logic toward_zero_up(input logic neg, input logic inexact);
    return neg & inexact;
  endfunction

  function automatic logic nearest_up(input logic lsb, input logic g, input logic s);
    return g & (s | lsb);
  endfunction

  logic [WORD_W-1:0] hi;
  logic [LO_W-1:0]   lo;
  logic              inc;

  assign hi  = prod[PROD_W-1 -: WORD_W];
  assign lo  = prod[LO_W-1:0];
  assign inc = trunc ? toward_zero_up(prod[PROD_W-1], |lo)
                     : nearest_up(hi[0], lo[LO_W-1], |lo[LO_W-2:0]);
  assign sat_ev = inc && (hi == MAX_POS);
  assign word   = sat_ev ? MAX_POS : hi + {{(WORD_W-1){1'b0}}, inc};
endmodule

// File: rtl/rnd_out_stage.sv
module rnd_out_stage #(
  parameter int REG_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [WORD_W-1:0] word,
  output logic              valid_out,
  output logic [REG_W-1:0]  res_word
);
  localparam int LOW_W = REG_W - WORD_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      res_word  <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) res_word <= {word, {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int MANT_W = 48,
  parameter int PROD_W = 64,
  parameter int REG_W  = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_in,
  input  logic [1:0]          fmt,
  input  logic                rnd_trunc,
  input  logic                f_sign,
  input  logic [EXP_W-1:0]    f_exp,
  input  logic [MANT_W-1:0]   f_mant,
  input  logic [PROD_W-1:0]   fx_prod,
  input  logic [REG_W-1:0]    reg_in,
  output logic                valid_out,
  output logic [REG_W-1:0]    res_word
);
  import rnd_pkg::*;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int LOW_W  = REG_W - WORD_W;

  logic [WORD_W-1:0] flt_word, frac_word, int_word, opnd_word;
  logic [WORD_W-1:0] sel_word;
  logic              flt_carry, fx_sat;

  rnd_flt_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W)) flt_i (
    .sign(f_sign), .exp_in(f_exp), .mant(f_mant), .trunc(rnd_trunc),
    .word(flt_word), .carry_ev(flt_carry)
  );

  rnd_frac_core #(.PROD_W(PROD_W), .WORD_W(WORD_W)) frac_i (
    .prod(fx_prod), .trunc(rnd_trunc), .word(frac_word), .sat_ev(fx_sat)
  );

  assign int_word  = fx_prod[WORD_W-1:0];
  assign opnd_word = reg_in[REG_W-1:LOW_W];

  always_comb begin
    unique case (rnd_fmt_e'(fmt))
      FMT_FLT:  sel_word = flt_word;
      FMT_FRAC: sel_word = frac_word;
      FMT_INT:  sel_word = int_word;
      default:  sel_word = opnd_word;
    endcase
  end

  rnd_out_stage #(.REG_W(REG_W), .WORD_W(WORD_W)) out_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .word(sel_word),
    .valid_out(valid_out), .res_word(res_word)
  );
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int PROD_W = 64,
  parameter int REG_W  = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic [1:0]        fmt,
  input logic              rnd_trunc,
  input logic [PROD_W-1:0] fx_prod,
  input logic [REG_W-1:0]  reg_in,
  input logic              valid_out,
  input logic [REG_W-1:0]  res_word,
  input logic              flt_carry,
  input logic              fx_sat
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int LOW_W  = REG_W - WORD_W;
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_low_byte_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (res_word[LOW_W-1:0] == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (valid_out == $past(valid_in)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(valid_in)) |-> $stable(res_word));

  assert_carry_frac_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(valid_in && fmt == 2'd0 && flt_carry))
      |-> (res_word[LOW_W+FRAC_W-1:LOW_W] == '0));

  assert_no_inf_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(valid_in && fmt == 2'd0 && rnd_trunc))
      |-> (res_word[REG_W-2 -: EXP_W] != '1));

  assert_frac_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(valid_in && fmt == 2'd1 && fx_sat))
      |-> (res_word[REG_W-1:LOW_W] == MAX_POS));

  assert_int_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(valid_in && fmt == 2'd2))
      |-> (res_word[REG_W-1:LOW_W] == $past(fx_prod[WORD_W-1:0])));

  assert_operand_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(valid_in && fmt == 2'd3))
      |-> (res_word[REG_W-1:LOW_W] == $past(reg_in[REG_W-1:LOW_W])));
endmodule

bind rnd_unit rnd_unit_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .PROD_W(PROD_W), .REG_W(REG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt(fmt),
  .rnd_trunc(rnd_trunc), .fx_prod(fx_prod), .reg_in(reg_in),
  .valid_out(valid_out), .res_word(res_word),
  .flt_carry(flt_carry), .fx_sat(fx_sat)
);

// File: tb/rnd_unit_tb.sv
module rnd_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  typedef struct packed {
    logic [1:0]  fmt;
    logic        trunc;
    logic        sign;
    logic [7:0]  exp;
    logic [47:0] mant;
    logic [63:0] prod;
    logic [39:0] regv;
    logic [31:0] want;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'h7F, 48'h800000_000000, 64'h0, 40'h0, 32'h3F800000, 8'd4},  // R4 exact
    '{2'd0, 1'b1, 1'b0, 8'h7F, 48'h800001_FFFFFF, 64'h0, 40'h0, 32'h3F800001, 8'd3},  // R3
    '{2'd0, 1'b0, 1'b0, 8'h7F, 48'h800001_FFFFFF, 64'h0, 40'h0, 32'h3F800002, 8'd4},  // R4 up
    '{2'd0, 1'b0, 1'b0, 8'h7F, 48'h800002_800000, 64'h0, 40'h0, 32'h3F800002, 8'd4},  // R4 tie even
    '{2'd0, 1'b0, 1'b0, 8'h7F, 48'h800003_800000, 64'h0, 40'h0, 32'h3F800004, 8'd4},  // R4 tie odd
    '{2'd0, 1'b0, 1'b0, 8'h7F, 48'h800003_7FFFFF, 64'h0, 40'h0, 32'h3F800003, 8'd4},  // R4 below half
    '{2'd0, 1'b0, 1'b1, 8'h80, 48'hFFFFFF_800000, 64'h0, 40'h0, 32'hC0800000, 8'd5},  // R5 carry
    '{2'd0, 1'b1, 1'b1, 8'h80, 48'hFFFFFF_800000, 64'h0, 40'h0, 32'hC07FFFFF, 8'd3},  // R3 negative
    '{2'd0, 1'b0, 1'b0, 8'hFE, 48'hFFFFFF_800000, 64'h0, 40'h0, 32'h7F800000, 8'd6},  // R6 top tie
    '{2'd0, 1'b1, 1'b0, 8'hFE, 48'hFFFFFF_800000, 64'h0, 40'h0, 32'h7F7FFFFF, 8'd3},  // R3 top
    '{2'd0, 1'b0, 1'b1, 8'hFF, 48'h800000_000000, 64'h0, 40'h0, 32'hFF800000, 8'd6},  // R6
    '{2'd0, 1'b1, 1'b1, 8'hFF, 48'h800000_000000, 64'h0, 40'h0, 32'hFF7FFFFF, 8'd7},  // R7
    '{2'd0, 1'b0, 1'b1, 8'h00, 48'h123456_789ABC, 64'h0, 40'h0, 32'h80000000, 8'd8},  // R8
    '{2'd1, 1'b1, 1'b0, 8'h00, 48'h0, 64'h12345678_9ABCDEF0, 40'h0, 32'h12345678, 8'd9},  // R9
    '{2'd1, 1'b1, 1'b0, 8'h00, 48'h0, 64'hEDCBA987_00000001, 40'h0, 32'hEDCBA988, 8'd9},  // R9
    '{2'd1, 1'b1, 1'b0, 8'h00, 48'h0, 64'hEDCBA987_00000000, 40'h0, 32'hEDCBA987, 8'd9},  // R9
    '{2'd1, 1'b0, 1'b0, 8'h00, 48'h0, 64'h12345678_80000000, 40'h0, 32'h12345678, 8'd10}, // R10
    '{2'd1, 1'b0, 1'b0, 8'h00, 48'h0, 64'h12345679_80000000, 40'h0, 32'h1234567A, 8'd10}, // R10
    '{2'd1, 1'b0, 1'b0, 8'h00, 48'h0, 64'h12345679_7FFFFFFF, 40'h0, 32'h12345679, 8'd10}, // R10
    '{2'd1, 1'b0, 1'b0, 8'h00, 48'h0, 64'h7FFFFFFF_C0000000, 40'h0, 32'h7FFFFFFF, 8'd10}, // R10 sat
    '{2'd1, 1'b0, 1'b0, 8'h00, 48'h0, 64'hFFFFFFFF_80000001, 40'h0, 32'h00000000, 8'd10}, // R10
    '{2'd1, 1'b0, 1'b0, 8'h00, 48'h0, 64'hFFFFFFFF_80000000, 40'h0, 32'h00000000, 8'd10}, // R10
    '{2'd2, 1'b0, 1'b0, 8'h00, 48'h0, 64'hDEADBEEF_CAFEF00D, 40'h0, 32'hCAFEF00D, 8'd11}, // R11
    '{2'd2, 1'b1, 1'b0, 8'h00, 48'h0, 64'hDEADBEEF_CAFEF00D, 40'h0, 32'hCAFEF00D, 8'd11}, // R11
    '{2'd3, 1'b0, 1'b0, 8'h00, 48'h0, 64'h0, 40'h12345678_9A, 32'h12345678, 8'd12},      // R12
    '{2'd3, 1'b1, 1'b0, 8'h00, 48'h0, 64'h0, 40'h12345678_FF, 32'h12345678, 8'd12}       // R12
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        rnd_trunc = 1'b0;
  logic        f_sign = 1'b0;
  logic [7:0]  f_exp = 8'h0;
  logic [47:0] f_mant = '0;
  logic [63:0] fx_prod = '0;
  logic [39:0] reg_in = '0;
  logic        valid_out;
  logic [39:0] res_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rnd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt(fmt),
    .rnd_trunc(rnd_trunc), .f_sign(f_sign), .f_exp(f_exp), .f_mant(f_mant),
    .fx_prod(fx_prod), .reg_in(reg_in), .valid_out(valid_out), .res_word(res_word)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic drive(input vec_t v);
    fmt = v.fmt; rnd_trunc = v.trunc; f_sign = v.sign; f_exp = v.exp;
    f_mant = v.mant; fx_prod = v.prod; reg_in = v.regv;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset valid_out", {39'h0, valid_out}, 40'h0);
    check("R2 reset res_word", res_word, 40'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      valid_in = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), res_word, {VECS[i].want, 8'h00});
      check("R1 low byte clear", {32'h0, res_word[7:0]}, 40'h0);
      check("R2 valid_out one cycle later", {39'h0, valid_out}, 40'h1);
    end
    // R2 hold while idle: inputs change without valid_in
    valid_in = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    check("R2 valid_out drops", {39'h0, valid_out}, 40'h0);
    check("R2 result held", res_word, {32'h12345678, 8'h00});
    // R12 low byte of operand has no effect
    fmt = 2'd3; reg_in = 40'hA5A5A5A5_00; valid_in = 1'b1;
    @(negedge clk);
    check("R12 operand low byte zero", res_word, 40'hA5A5A5A5_00);
    reg_in = 40'hA5A5A5A5_7E;
    @(negedge clk);
    check("R12 operand low byte ignored", res_word, 40'hA5A5A5A5_00);
    // R6 negative top tie in nearest gives negative infinity
    fmt = 2'd0; rnd_trunc = 1'b0; f_sign = 1'b1; f_exp = 8'hFE; f_mant = 48'hFFFFFF_800000;
    @(negedge clk);
    check("R6 negative top tie", res_word, {32'hFF800000, 8'h00});
    // R2 reset clears a held result
    valid_in = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset clears word", res_word, 40'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule